// File: doc/BRIEF.md
# Three-Phase Dual-Duty Buck-Boost Duty Calculator

This block turns three signed phase voltage commands into switch duty words for an inverter made of three non-inverting four-switch buck-boost cells, one per phase. Each cell must hold a strictly positive output voltage. The phase command is therefore lifted by an offset into a cell reference. That reference is compared with the measured input voltage, which puts the cell in buck or boost operation. In either operation the stage that is not regulating is held fully on, at a duty of exactly one. Only the regulating stage gets a fractional duty, formed by dividing the smaller of reference and input voltage by the larger.

Two offset rules are available. In sinusoidal mode the offset is the command vector magnitude plus a signed correction term. In discontinuous mode the offset lifts the lowest phase command exactly to the input voltage, so that the phase stops switching. A start pulse captures all inputs. The three phases are then worked through one after another by a shared 16-step restoring divider, and a done pulse marks that all six duty words are up to date. If the input voltage is zero or below a given floor, all duties are forced to zero and an error flag is raised.

State machine states: IDLE (waiting for start), PREP (select phase, form reference, load divider), DIV (sixteen divide steps), NEXT (write the phase's duty words, advance phase or finish), FAULT (zero outputs, raise error). Transitions: IDLE to PREP on start with valid input voltage; IDLE to FAULT on start with invalid input voltage; PREP to DIV always; DIV to NEXT on the last divide step; NEXT to PREP while phases remain; NEXT to IDLE after phase 2; FAULT to IDLE always.

Top module: `ydc_calc`

## Requirements
- R1: After reset all duty fields, the boost mask, done and err are zero.
- R2: With mode_sel equal to 0, the reference of phase p is cmd_p + mag + corr (two's-complement commands and correction, unsigned magnitude), and a negative sum is clamped to 0.
- R3: With mode_sel not 0, the reference of phase p is cmd_p − min(cmd_0, cmd_1, cmd_2) + vin, so the lowest phase gets buck duty and boost-complement duty both at 0x8000.
- R4: When a phase reference is greater than vin, its buck duty is 0x8000, its boost-complement duty is floor(vin·32768/ref), and its boost_mask bit is 1.
- R5: When a phase reference is less than or equal to vin, its boost-complement duty is 0x8000, its buck duty is floor(ref·32768/vin), and its boost_mask bit is 0.
- R6: Duties are unsigned Q1.15 with 0x8000 meaning one and never exceed 0x8000. Phase p occupies bits [16p+15:16p] of buck_duty and of boost_cduty, and bit p of boost_mask. Phase p's command is bits [16p+15:16p] of cmd_bus.
- R7: Counting the edge that samples start as edge 0, the outputs of phase p change at edge 18·(p+1) and the other phases keep their values. done is high for exactly one cycle, following edge 54.
- R8: If vin is 0 or vin < vin_min when start is sampled, then at the next edge all duties and mask bits become 0 and err and done go high, with done high for one cycle. err stays set until a start with valid vin is sampled, which clears it at that edge.
- R9: A start pulse while a computation is running is ignored, and input changes after the capture edge do not affect the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture inputs and begin computation (sampled in IDLE only) |
| mode_sel | input | 2 | 0: sinusoidal offset rule; any other value: discontinuous rule |
| cmd_bus | input | 48 | Three signed 16-bit phase commands, phase p at [16p+15:16p] |
| mag | input | 16 | Unsigned command vector magnitude |
| corr | input | 16 | Signed offset correction term |
| vin | input | 16 | Unsigned measured input voltage |
| vin_min | input | 16 | Unsigned lowest acceptable input voltage |
| buck_duty | output | 48 | Buck-stage duty per phase, Q1.15 |
| boost_cduty | output | 48 | Complement of boost-stage duty per phase, Q1.15 |
| boost_mask | output | 3 | 1 where the phase runs in boost operation |
| done | output | 1 | One-cycle pulse when results are complete |
| err | output | 1 | Input voltage fault flag |

## Verification
A phase index that goes wrong shows as a duty word landing in the wrong field at one of the 18-cycle boundaries, at the latest 54 cycles after start. A divide step counter that is off by one moves every update and the done pulse by a cycle, and corrupts the quotient bits. A buck/boost flag that is latched wrongly shows as a full-scale word in the wrong port, together with a mismatched mask bit, at the phase's own write edge. The bench compares every field, done and err on every clock of each run, so any of these is reported in the cycle where it first appears.

// File: rtl/ydc_pkg.sv
package ydc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV,
        ST_NEXT,
        ST_FAULT
    } ydc_state_e;
endpackage

// File: rtl/ydc_refgen.sv
// Forms the positive cell reference for every phase from captured inputs.
module ydc_refgen #(
    parameter int W   = 16,
    parameter int NPH = 3,
    parameter int RW  = W + 1
) (
    input  logic [NPH*W-1:0] cmd_bus,
    input  logic [W-1:0]     mag,
    input  logic [W-1:0]     corr,
    input  logic [W-1:0]     vin,
    input  logic             dpwm,
    output logic [RW-1:0]    ref_arr [NPH]
);
    localparam int SW = W + 3;

    logic signed [SW-1:0] cext [NPH];
    logic signed [SW-1:0] cmin;
    logic signed [SW-1:0] mag_x;
    logic signed [SW-1:0] corr_x;
    logic signed [SW-1:0] vin_x;

    assign mag_x  = $signed({{(SW-W){1'b0}}, mag});
    assign vin_x  = $signed({{(SW-W){1'b0}}, vin});
    assign corr_x = $signed({{(SW-W){corr[W-1]}}, corr});

    always_comb begin
        cmin = cext[0];
        for (int i = 1; i < NPH; i++) begin
            if (cext[i] < cmin) cmin = cext[i];
        end
    end

    for (genvar gp = 0; gp < NPH; gp++) begin : g_ph
        logic signed [SW-1:0] sum;
        assign cext[gp] = $signed({{(SW-W){cmd_bus[gp*W+W-1]}}, cmd_bus[gp*W +: W]});
        assign sum = dpwm ? (cext[gp] - cmin + vin_x)
                          : (cext[gp] + mag_x + corr_x);
        // negative clamps to zero, excess saturates
        assign ref_arr[gp] = sum[SW-1]           ? '0 :
                             (|sum[SW-2:RW])     ? '1 :
                             sum[RW-1:0];
    end
endmodule

// File: rtl/ydc_div.sv
// Restoring divider for num <= den: quotient = floor(num * 2^(QW-1) / den).
module ydc_div #(
    parameter int NUM_W = 17,
    parameter int QW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] den,
    output logic [QW-1:0]    quo,
    output logic             last
);
    localparam int CW = $clog2(QW);

    logic [NUM_W:0]   rem;
    logic [NUM_W:0]   diff;
    logic [NUM_W-1:0] den_q;
    logic [CW-1:0]    cnt;

    assign diff = rem - {1'b0, den_q};
    assign last = (cnt == CW'(QW-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            quo   <= '0;
            cnt   <= '0;
        end else if (load) begin
            rem   <= {1'b0, num};
            den_q <= den;
            quo   <= '0;
            cnt   <= '0;
        end else if (step) begin
            if (!diff[NUM_W]) begin
                quo <= {quo[QW-2:0], 1'b1};
                rem <= {diff[NUM_W-1:0], 1'b0};
            end else begin
                quo <= {quo[QW-2:0], 1'b0};
                rem <= {rem[NUM_W-1:0], 1'b0};
            end
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ydc_calc.sv
module ydc_calc
    import ydc_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 15,
    parameter int NPH  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [1:0]                mode_sel,
    input  logic [NPH*W-1:0]          cmd_bus,
    input  logic [W-1:0]              mag,
    input  logic [W-1:0]              corr,
    input  logic [W-1:0]              vin,
    input  logic [W-1:0]              vin_min,
    output logic [NPH*(FRAC+1)-1:0]   buck_duty,
    output logic [NPH*(FRAC+1)-1:0]   boost_cduty,
    output logic [NPH-1:0]            boost_mask,
    output logic                      done,
    output logic                      err
);
    localparam int DW  = FRAC + 1;
    localparam int RW  = W + 1;
    localparam int PHW = (NPH > 1) ? $clog2(NPH) : 1;
    localparam logic [DW-1:0] ONE = {1'b1, {FRAC{1'b0}}};

    ydc_state_e state, state_nx;

    logic [NPH*W-1:0] cmd_q;
    logic [W-1:0]     mag_q, corr_q, vin_q;
    logic             dpwm_q;
    logic [PHW-1:0]   idx;
    logic             boost_q;
    logic [RW-1:0]    ref_arr [NPH];
    logic [RW-1:0]    sel_ref, div_num, div_den;
    logic             sel_boost, vin_bad, div_last, last_phase;
    logic [DW-1:0]    quo, q_sat;
    logic [DW-1:0]    buck_r  [NPH];
    logic [DW-1:0]    cduty_r [NPH];

    ydc_refgen #(.W(W), .NPH(NPH), .RW(RW)) u_ref (
        .cmd_bus (cmd_q),
        .mag     (mag_q),
        .corr    (corr_q),
        .vin     (vin_q),
        .dpwm    (dpwm_q),
        .ref_arr (ref_arr)
    );

    assign sel_ref    = ref_arr[idx];
    assign sel_boost  = sel_ref > {1'b0, vin_q};
    assign div_num    = sel_boost ? {1'b0, vin_q} : sel_ref;
    assign div_den    = sel_boost ? sel_ref : {1'b0, vin_q};
    assign vin_bad    = (vin == '0) || (vin < vin_min);
    assign last_phase = (idx == PHW'(NPH-1));
    assign q_sat      = (quo > ONE) ? ONE : quo;

    ydc_div #(.NUM_W(RW), .QW(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_PREP),
        .step  (state == ST_DIV),
        .num   (div_num),
        .den   (div_den),
        .quo   (quo),
        .last  (div_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = vin_bad ? ST_FAULT : ST_PREP;
            ST_PREP:  state_nx = ST_DIV;
            ST_DIV:   if (div_last) state_nx = ST_NEXT;
            ST_NEXT:  state_nx = last_phase ? ST_IDLE : ST_PREP;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            mag_q      <= '0;
            corr_q     <= '0;
            vin_q      <= '0;
            dpwm_q     <= 1'b0;
            idx        <= '0;
            boost_q    <= 1'b0;
            boost_mask <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
            for (int i = 0; i < NPH; i++) begin
                buck_r[i]  <= '0;
                cduty_r[i] <= '0;
            end
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q  <= cmd_bus;
                        mag_q  <= mag;
                        corr_q <= corr;
                        vin_q  <= vin;
                        dpwm_q <= (mode_sel != 2'd0);
                        idx    <= '0;
                        if (!vin_bad) err <= 1'b0;
                    end
                end
                ST_PREP: boost_q <= sel_boost;
                ST_DIV: ;
                ST_NEXT: begin
                    boost_mask[idx] <= boost_q;
                    if (boost_q) begin
                        buck_r[idx]  <= ONE;
                        cduty_r[idx] <= q_sat;
                    end else begin
                        buck_r[idx]  <= q_sat;
                        cduty_r[idx] <= ONE;
                    end
                    if (last_phase) begin
                        idx  <= '0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_FAULT: begin
                    for (int i = 0; i < NPH; i++) begin
                        buck_r[i]  <= '0;
                        cduty_r[i] <= '0;
                    end
                    boost_mask <= '0;
                    err        <= 1'b1;
                    done       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    for (genvar gp = 0; gp < NPH; gp++) begin : g_out
        assign buck_duty[gp*DW +: DW]   = buck_r[gp];
        assign boost_cduty[gp*DW +: DW] = cduty_r[gp];
    end
endmodule

// File: rtl/ydc_chk.sv
module ydc_chk #(
    parameter int W    = 16,
    parameter int FRAC = 15,
    parameter int NPH  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [NPH*(FRAC+1)-1:0] buck_duty,
    input logic [NPH*(FRAC+1)-1:0] boost_cduty,
    input logic [NPH-1:0]          boost_mask,
    input logic                    done,
    input logic                    err
);
    localparam int DW = FRAC + 1;
    localparam logic [DW-1:0] FULL = {1'b1, {FRAC{1'b0}}};

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(err) || done));

    for (genvar gp = 0; gp < NPH; gp++) begin : g_ph
        assert_duty_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (buck_duty[gp*DW +: DW] <= FULL) && (boost_cduty[gp*DW +: DW] <= FULL));

        assert_boost_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !err && boost_mask[gp]) |->
                (buck_duty[gp*DW +: DW] == FULL) && (boost_cduty[gp*DW +: DW] < FULL));

        assert_buck_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !err && !boost_mask[gp]) |-> (boost_cduty[gp*DW +: DW] == FULL));

        assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (done && err) |->
                (buck_duty[gp*DW +: DW] == '0) && (boost_cduty[gp*DW +: DW] == '0)
                && !boost_mask[gp]);
    end
endmodule

bind ydc_calc ydc_chk #(.W(W), .FRAC(FRAC), .NPH(NPH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .buck_duty   (buck_duty),
    .boost_cduty (boost_cduty),
    .boost_mask  (boost_mask),
    .done        (done),
    .err         (err)
);

// File: tb/sim_ydc_calc.sv
`timescale 1ns/1ps
module sim_ydc_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode_sel = '0;
    logic [47:0] cmd_bus = '0;
    logic [15:0] mag = '0, corr = '0, vin = '0, vin_min = '0;
    logic [47:0] buck_duty, boost_cduty;
    logic [2:0]  boost_mask;
    logic        done, err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model state: what the ports should show now
    int cur_b [3];
    int cur_c [3];
    int cur_m [3];
    int cur_err = 0;

    always #2.5 clk = ~clk;

    ydc_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
        .cmd_bus(cmd_bus), .mag(mag), .corr(corr), .vin(vin), .vin_min(vin_min),
        .buck_duty(buck_duty), .boost_cduty(boost_cduty), .boost_mask(boost_mask),
        .done(done), .err(err)
    );

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag, input int exp_done);
        for (int p = 0; p < 3; p++) begin
            check_int(tag, $sformatf("buck duty phase %0d", p), int'(buck_duty[p*16 +: 16]), cur_b[p]);
            check_int(tag, $sformatf("boost cduty phase %0d", p), int'(boost_cduty[p*16 +: 16]), cur_c[p]);
            check_int("R4", $sformatf("boost mask phase %0d", p), int'(boost_mask[p]), cur_m[p]);
        end
        check_int("R7", "done", int'(done), exp_done);
        check_int("R8", "err", int'(err), cur_err);
    endtask

    // one computation; glitch pulses start mid-run with altered commands (R9)
    task automatic run(input int c0, input int c1, input int c2, input int mg, input int cr,
                       input int v, input int vm, input int md, input string tag, input bit glitch);
        longint cmd [3];
        longint r, lo;
        int nb [3];
        int nc [3];
        int nm [3];
        bit fault;
        cmd[0] = c0; cmd[1] = c1; cmd[2] = c2;
        fault = (v == 0) || (v < vm);
        lo = cmd[0];
        for (int p = 1; p < 3; p++) if (cmd[p] < lo) lo = cmd[p];
        for (int p = 0; p < 3; p++) begin
            if (md == 0) r = cmd[p] + mg + cr;          // R2 offset rule
            else         r = cmd[p] - lo + v;           // R3 offset rule
            if (r < 0) r = 0;
            if (!fault && r > v) begin                   // R4 boost
                nb[p] = 32768; nc[p] = int'((longint'(v) * 32768) / r); nm[p] = 1;
            end else if (!fault) begin                   // R5 buck
                nc[p] = 32768; nb[p] = int'((r * 32768) / v); nm[p] = 0;
            end else begin
                nb[p] = 0; nc[p] = 0; nm[p] = 0;
            end
        end
        @(negedge clk);
        cmd_bus  = {16'(c2), 16'(c1), 16'(c0)};
        mag      = 16'(mg);
        corr     = 16'(cr);
        vin      = 16'(v);
        vin_min  = 16'(vm);
        mode_sel = 2'(md);
        start    = 1'b1;
        for (int k = 1; k <= (fault ? 6 : 60); k++) begin
            @(posedge clk);
            #1;
            if (k == 1) begin
                start = 1'b0;
                if (!fault) cur_err = 0;                 // R8 clear on valid start
            end
            if (glitch && k == 9) begin
                start   = 1'b1;
                cmd_bus = ~cmd_bus;
                vin     = 16'd3;
            end
            if (glitch && k == 10) start = 1'b0;
            if (fault) begin
                if (k == 2) begin
                    for (int p = 0; p < 3; p++) begin cur_b[p] = 0; cur_c[p] = 0; cur_m[p] = 0; end
                    cur_err = 1;
                end
                compare_all(tag, (k == 2) ? 1 : 0);
            end else begin
                for (int p = 0; p < 3; p++) begin
                    if (k == 18*(p+1) + 1) begin         // R7 phase write edge
                        cur_b[p] = nb[p]; cur_c[p] = nc[p]; cur_m[p] = nm[p];
                    end
                end
                compare_all(tag, (k == 55) ? 1 : 0);
            end
        end
    endtask

    initial begin
        for (int p = 0; p < 3; p++) begin cur_b[p] = 0; cur_c[p] = 0; cur_m[p] = 0; end
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1", 0);                            // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare_all("R1", 0);
        run(1000, -500, -500, 4000, 0, 10000, 100, 0, "R5", 1'b0);
        run(8000, -4000, -4000, 8000, 100, 10000, 100, 0, "R4", 1'b0);
        run(-9000, 0, 3000, 4000, -200, 10000, 100, 0, "R2", 1'b0);
        run(0, 2598, -2598, 0, 0, 12000, 100, 1, "R3", 1'b0);
        run(3000, -1500, 500, 7000, 50, 9000, 0, 2, "R3", 1'b0);
        run(32767, -32768, 0, 65535, 32767, 1, 0, 0, "R6", 1'b0);
        run(0, 0, 0, 0, 0, 65535, 0, 0, "R6", 1'b0);
        run(1200, 300, -1500, 5000, 0, 0, 0, 0, "R8", 1'b0);
        run(1200, 300, -1500, 5000, 0, 400, 500, 0, "R8", 1'b0);
        run(6000, -3000, -3000, 6000, 0, 8000, 500, 0, "R8", 1'b0);
        run(6000, -3000, -3000, 6000, 0, 8000, 500, 0, "R9", 1'b1);
        run(-2000, 4000, -2000, 9000, -300, 7000, 1000, 0, "R9", 1'b1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule